// File: doc/BRIEF.md
# Serial-Programmed Gain and Power-Down Register Slave

This block sits beside a programmable-gain analog front end and gives it a small register bank that a host programs over a four-wire serial link. The host lowers an active-low select line and clocks in 16-bit words on the serial data input. The first byte of each word is the register address and the second byte is the data. A write takes effect when the sixteenth bit of a word arrives. Several words may follow one another inside a single select window.

One control register drives the analog stage. Its low six bits give an attenuation code, which is limited to the range 0 to 32 dB. One higher bit requests power-down, and the block ORs that bit with an external power-down pin. The serial clock and select are brought into the system clock domain through two-stage synchronisers. Bits are taken on detected rising edges of the serial clock, so the high and low times of that clock may be as uneven or as long as the host likes. During each word, the serial output returns the contents that the previously addressed register held before that word's write.

Top module: `gain_spi_regs`

## Requirements
- R1: After reset, register 0x00 holds 0xA5, register 0x01 holds 0x00, register 0x02 holds 0x20 and register 0x03 holds 0x3C. The attenuation output is then 32, power-down is low and sdo is low.
- R2: Serial-clock edges that occur while cs_n is high change no register and no output.
- R3: A word is 16 bits, sent MSB first. Bits 15:8 are the address and bits 7:0 are the data. The register is written on the 16th rising sclk edge of the word, and sclk may have any duty cycle.
- R4: One cs_n low window may carry several consecutive words, and each of them is written in turn.
- R5: Bits left over after the last complete word when cs_n rises cause no write. Every new frame starts counting at bit 0.
- R6: The attenuation output equals bits 5:0 of register 0x02, except that codes above 32 are output as 32.
- R7: The power-down output equals bit 6 of register 0x02 ORed with the active-high pd_pin input.
- R8: Register contents stay unchanged while power-down is asserted, and change only through serial writes or reset.
- R9: During the word that follows a word addressed to A, sdo carries the contents A held before that earlier word's write, MSB first over the first 8 bits and 0 over the last 8. The first word of a frame returns all zeros, and sdo is low outside a frame.
- R10: Writes to addresses 0x04 and above are ignored, and reading such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, used as the power-on reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial readback data |
| pd_pin | input | 1 | External power-down request, active high |
| atten | output | 6 | Attenuation code, 0 to 32 dB |
| pd_out | output | 1 | Effective power-down |

## Verification
The bench builds the block with its defaults: a four-register bank, two synchroniser stages, the control register at 0x02 and a clamp limit of 32. With four registers, the bench can read back every implemented address, and address 0x10 exercises the out-of-range path. Because the clamp limit sits inside the six-bit code space, codes 31, 32, 33 and 63 test both sides of the clamp. The serial clock is driven with unequal high and low times, several words per frame, and a frame that ends after a partial word.

// File: rtl/gspi_pkg.sv
// Shared widths and the write-request type for the serial register slave.
package gspi_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/gspi_sync.sv
// Brings cs_n, sclk and sdi into the clk domain through STAGES flops each,
// and flags rising edges of the synchronised sclk.
// Assumes sclk high and low phases each last several clk periods and that
// sdi is stable around the sclk rising edge.
module gspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sdi_s
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sdi_pipe;
    logic              sclk_last;

    // Shift each input through its synchroniser chain and keep the last sclk level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            sclk_pipe <= '0;
            sdi_pipe  <= '0;
            sclk_last <= 1'b0;
        end else begin
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
            sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi};
            sclk_last <= sclk_pipe[STAGES-1];
        end
    end

    assign cs_act    = ~cs_pipe[STAGES-1];
    assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_last;
    assign sdi_s     = sdi_pipe[STAGES-1];
endmodule

// File: rtl/gspi_framer.sv
// Assembles 16-bit words from synchronised serial bits, issues one write
// request per complete word and shifts readback data out on sdo.
// Assumes the inputs come from gspi_sync. The bit count clears whenever
// select is inactive, so a partial word is dropped.
module gspi_framer
    import gspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output wr_req_t           wr_req,
    output logic              sdo
);
    logic [WORD_W-2:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] out_q;
    logic [WORD_W-1:0] word_full;
    logic              last_bit;

    assign word_full = {shift_q, sdi_s};
    assign last_bit  = (cnt_q == CNT_W'(WORD_W - 1));
    assign rd_addr   = word_full[WORD_W-1 -: ADDR_W];
    assign sdo       = out_q[DATA_W-1];

    // Count bits, shift data in, commit a word on its last bit and move readback out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            out_q   <= '0;
            wr_en   <= 1'b0;
            wr_req  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_act) begin
                cnt_q <= '0;
                out_q <= '0;
            end else if (sclk_rise) begin
                shift_q <= word_full[WORD_W-2:0];
                if (last_bit) begin
                    cnt_q  <= '0;
                    wr_en  <= 1'b1;
                    wr_req <= word_full;
                    out_q  <= rd_data;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    out_q <= {out_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/gspi_regbank.sv
// Holds NUM_REGS byte registers that load from DEFAULTS on reset. It writes
// on a request whose address is inside the bank and reads back combinationally.
// Assumes at most one write request per cycle. Addresses outside the bank
// read as zero.
module gspi_regbank
    import gspi_pkg::*;
#(
    parameter int                         NUM_REGS = 4,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  wr_req_t                    wr_req,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    // Load defaults on reset, otherwise write the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= DEFAULTS[i*DATA_W +: DATA_W];
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_req.addr == ADDR_W'(i)) begin
                    regs_q[i] <= wr_req.data;
                end
            end
        end
    end

    // Select the addressed register for readback, or zero when out of range.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end
endmodule

// File: rtl/gspi_gain_decode.sv
// Turns the control register into a clamped attenuation code and the
// effective power-down level.
// Assumes ATT_MAX fits in ATT_W bits and PD_BIT lies above the code field.
module gspi_gain_decode
    import gspi_pkg::*;
#(
    parameter int ATT_W   = 6,
    parameter int ATT_MAX = 32,
    parameter int PD_BIT  = 6
) (
    input  logic [DATA_W-1:0] ctrl,
    input  logic              pd_pin,
    output logic [ATT_W-1:0]  atten,
    output logic              pd_out
);
    logic [ATT_W-1:0] code;

    assign code = ctrl[ATT_W-1:0];

    // Clamp the code to the largest valid step.
    always_comb begin
        if (code > ATT_W'(ATT_MAX)) begin
            atten = ATT_W'(ATT_MAX);
        end else begin
            atten = code;
        end
    end

    assign pd_out = ctrl[PD_BIT] | pd_pin;
endmodule

// File: rtl/gain_spi_regs.sv
// Top of the serial register slave for a programmable-gain front end.
// It joins the synchroniser, word framer, register bank and gain decode.
// Assumes rst_n is applied at power-up, and that cs_n changes only while
// sclk is low.
module gain_spi_regs
    import gspi_pkg::*;
#(
    parameter int                         NUM_REGS  = 4,
    parameter int                         SYNC_STG  = 2,
    parameter int                         GAIN_ADDR = 2,
    parameter int                         PD_BIT    = 6,
    parameter int                         ATT_W     = 6,
    parameter int                         ATT_MAX   = 32,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS  = 32'h3C20_00A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    input  logic             pd_pin,
    output logic [ATT_W-1:0] atten,
    output logic             pd_out
);
    localparam int CTRL_LSB = GAIN_ADDR * DATA_W;

    logic                       cs_act;
    logic                       sclk_rise;
    logic                       sdi_s;
    logic [ADDR_W-1:0]          rd_addr;
    logic [DATA_W-1:0]          rd_data;
    logic                       wr_en;
    wr_req_t                    wr_req;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    gspi_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s)
    );

    gspi_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_req    (wr_req),
        .sdo       (sdo)
    );

    gspi_regbank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_req    (wr_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    gspi_gain_decode #(.ATT_W(ATT_W), .ATT_MAX(ATT_MAX), .PD_BIT(PD_BIT)) u_dec (
        .ctrl   (regs_flat[CTRL_LSB +: DATA_W]),
        .pd_pin (pd_pin),
        .atten  (atten),
        .pd_out (pd_out)
    );
endmodule

// File: rtl/gspi_checker.sv
// Property checks for gain_spi_regs, bound to every instance of the top.
module gspi_checker #(
    parameter int NUM_REGS = 4,
    parameter int ATT_W    = 6,
    parameter int ATT_MAX  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_act,
    input logic               wr_en,
    input logic [7:0]         wr_addr,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input logic               sdo,
    input logic               pd_pin,
    input logic               pd_out,
    input logic [ATT_W-1:0]   atten
);
    // R2: a write only follows a cycle in which select was active
    a_r2_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_act));

    // R4: each complete word produces one single-cycle write
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: attenuation never exceeds the clamp limit
    a_r6_atten_limit: assert property (@(posedge clk) disable iff (!rst_n)
        atten <= ATT_W'(ATT_MAX));

    // R7: the external pin always forces power-down
    a_r7_pin_forces_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pd_out);

    // R8: registers hold their values in every cycle without a write
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R9: sdo stays low once select has been inactive for two cycles
    a_r9_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !sdo);

    // R10: out-of-range writes leave the bank unchanged
    a_r10_unimpl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= 8'(NUM_REGS))) |=> $stable(regs_flat));
endmodule

bind gain_spi_regs gspi_checker #(
    .NUM_REGS (NUM_REGS),
    .ATT_W    (ATT_W),
    .ATT_MAX  (ATT_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .wr_en     (wr_en),
    .wr_addr   (wr_req.addr),
    .regs_flat (regs_flat),
    .sdo       (sdo),
    .pd_pin    (pd_pin),
    .pd_out    (pd_out),
    .atten     (atten)
);

// File: tb/gain_spi_regs_tb.sv
`timescale 1ns/1ps
module gain_spi_regs_tb;
    localparam int LO = 7;
    localparam int HI = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       pd_pin = 1'b0;
    logic       sdo;
    logic [5:0] atten;
    logic       pd_out;

    int         nchk = 0;
    int         nbad = 0;
    bit         done = 1'b0;
    logic [7:0] model [4];
    logic [7:0] rb_next;
    logic [7:0] exp_q [$];
    int         mon_cnt = 0;
    logic [7:0] mon_byte = 8'h00;

    always #4 clk = ~clk;

    gain_spi_regs u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .sdo    (sdo),
        .pd_pin (pd_pin),
        .atten  (atten),
        .pd_out (pd_out)
    );

    task automatic chk(string req, int act, int expv);
        nchk++;
        if (act != expv) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic void model_reset();
        model[0] = 8'hA5; model[1] = 8'h00; model[2] = 8'h20; model[3] = 8'h3C;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        model_reset();
        exp_q.delete();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic put_bit(logic b);
        sdi = b;
        repeat (LO) @(negedge clk);
        sclk = 1'b1;
        repeat (HI) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame_open();
        @(negedge clk);
        cs_n = 1'b0;
        rb_next = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (LO) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Driver: push the expected readback for this word, then send it.
    task automatic send_word(logic [7:0] a, logic [7:0] d);
        logic [15:0] w;
        w = {a, d};
        exp_q.push_back(rb_next);
        rb_next = (a < 8'd4) ? model[a[1:0]] : 8'h00;
        for (int i = 15; i >= 0; i--) put_bit(w[i]);
        if (a < 8'd4) model[a[1:0]] = d;
    endtask

    task automatic write1(logic [7:0] a, logic [7:0] d);
        frame_open();
        send_word(a, d);
        frame_close();
    endtask

    // Monitor: gather the first 8 sdo bits of each word and compare on the 16th.
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            mon_cnt = 0;
        end else begin
            if (mon_cnt < 8) mon_byte = {mon_byte[6:0], sdo};
            mon_cnt++;
            if (mon_cnt == 16) begin
                mon_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk("R9 readback without expectation", 1, 0);
                end else begin
                    chk("R9 readback", int'(mon_byte), int'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state
        chk("R1 atten", int'(atten), 32);
        chk("R1 pd_out", int'(pd_out), 0);
        chk("R1 sdo", int'(sdo), 0);

        // R3 R4: three words in one frame; readbacks check R9
        frame_open();
        send_word(8'h02, 8'h05);
        send_word(8'h00, 8'h11);
        send_word(8'h03, 8'h77);
        frame_close();
        chk("R3 R4 atten after multi-word", int'(atten), 5);

        frame_open();
        send_word(8'h00, 8'h22);
        send_word(8'h03, 8'h44);
        send_word(8'h01, 8'h00);
        frame_close();

        // R6: clamp boundaries
        write1(8'h02, 8'h1F); chk("R6 code 31", int'(atten), 31);
        write1(8'h02, 8'h20); chk("R6 code 32", int'(atten), 32);
        write1(8'h02, 8'h21); chk("R6 code 33", int'(atten), 32);
        write1(8'h02, 8'h3F); chk("R6 code 63", int'(atten), 32);
        write1(8'h02, 8'h00); chk("R6 code 0", int'(atten), 0);

        // R7: register bit and pin
        write1(8'h02, 8'h45);
        chk("R7 bit pd", int'(pd_out), 1);
        chk("R7 atten with pd", int'(atten), 5);
        write1(8'h02, 8'h05);
        chk("R7 bit cleared", int'(pd_out), 0);
        @(negedge clk); pd_pin = 1'b1; @(negedge clk);
        chk("R7 pin pd", int'(pd_out), 1);

        // R8: contents kept while powered down, read back during pd
        repeat (50) @(negedge clk);
        frame_open();
        send_word(8'h00, 8'h22);
        send_word(8'h03, 8'h44);
        send_word(8'h02, 8'h05);
        send_word(8'h01, 8'h00);
        frame_close();
        chk("R8 atten during pd", int'(atten), 5);
        @(negedge clk); pd_pin = 1'b0; @(negedge clk);
        chk("R7 pin released", int'(pd_out), 0);

        // R5: partial word discarded, next frame starts fresh
        frame_open();
        send_word(8'h02, 8'h09);
        for (int i = 15; i >= 7; i--) put_bit(logic'((16'h020A >> i) & 1));
        frame_close();
        chk("R5 partial ignored", int'(atten), 9);
        write1(8'h02, 8'h0B);
        chk("R5 fresh frame", int'(atten), 11);

        // R10: unimplemented address
        frame_open();
        send_word(8'h10, 8'hFF);
        send_word(8'h10, 8'h00);
        send_word(8'h02, 8'h0C);
        send_word(8'h00, 8'h22);
        send_word(8'h03, 8'h44);
        frame_close();
        chk("R10 atten", int'(atten), 12);

        // R2: sclk toggling with cs_n high
        for (int i = 15; i >= 0; i--) put_bit(logic'((16'h021E >> i) & 1));
        repeat (8) @(negedge clk);
        chk("R2 atten unchanged", int'(atten), 12);
        chk("R2 sdo idle", int'(sdo), 0);

        // R1: reset restores defaults
        do_reset();
        chk("R1 atten after reset", int'(atten), 32);
        frame_open();
        send_word(8'h00, 8'hA5);
        send_word(8'h03, 8'h3C);
        send_word(8'h01, 8'h00);
        frame_close();

        chk("R9 all readbacks consumed", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule